// File: doc/BRIEF.md
# DMA Request Router

This block sits between a chip's peripheral DMA request lines and its DMA channels. Software programs one 8-bit routing entry per request input, and the block uses it to decide which channel, if any, a request line drives. For each channel the block gives a registered request level. It also gives two one-cycle status pulses: one when the routed request becomes active, and one when it becomes inactive. The channel status logic downstream uses these pulses to record request-after-stop and end-of-receive events.

The entries are reached over a simple register bus with a write strobe and combinational read data. The entries occupy two separate address windows. The low window holds entries 0 to 63, and the high window holds the remaining entries. Three request-status words near the low window always read as zero and accept no writes. A write that names a channel the block does not have is stored without its enable bit, and the block raises an error pulse.

Top module: `dma_req_router`

## Requirements
- R1: After reset every routing entry reads as zero. Every channel level, every status pulse and the error flag are low.
- R2: Entry i for i from 0 to 63 is written and read at byte address 0x100 + 4*i. A read returns the entry in bits 7:0 of the read data, and the upper bits are zero.
- R3: Entry i for i from 64 to NUM_REQ-1 is written and read at byte address 0x1100 + 4*(i-64).
- R4: Addresses 0xE0, 0xE4 and 0xE8 always read as zero. A write to any of them changes no routing entry.
- R5: Bit 7 of an entry enables it, and bits 4:0 select the target channel. A channel's level is the OR of all enabled request inputs routed to it. The level appears one clock after the inputs.
- R6: A request input whose entry has bit 7 clear has no effect on any channel level or pulse.
- R7: When a channel's level goes from low to high, its request-after-stop pulse is high for exactly the first cycle of the new level, and is low in every other cycle.
- R8: When a channel's level goes from high to low, its end-of-receive pulse is high for exactly the first cycle of the low level.
- R9: A write with bit 7 set and a channel number at or above NUM_CH stores the value with bit 7 cleared. The error flag is then high for one cycle after that write. A write naming a valid channel does not raise the error flag.
- R10: While two enabled inputs share a channel, the channel gives no new pulse if one input rises while the other is already active. It also gives no pulse if one input falls while the other remains active.
- R11: Writes to addresses outside both windows and the status words change no entry, and reads from such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wdata | input | 8 | Write data, one entry wide |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| req_in | input | NUM_REQ | Peripheral request lines, active high |
| ch_level | output | NUM_CH | Registered routed request level per channel |
| ch_ras_pulse | output | NUM_CH | Request-after-stop pulse per channel |
| ch_eor_pulse | output | NUM_CH | End-of-receive pulse per channel |
| map_err | output | 1 | One-cycle flag after a write naming an absent channel |

## Verification
A corrupt routing entry shows up in two places. Reading that entry back returns the wrong value at once. A request on that line one clock later raises the wrong channel level, or no level at all. A stale level register shows up on the next input change: a pulse is missing or appears on the wrong edge. If two inputs share a channel, the pulse fires on a partial change, which the shared-channel scenario exposes within a cycle. A lost or mistimed error flag is seen in the cycle right after the offending write.

// File: rtl/dma_rr_pkg.sv
package dma_rr_pkg;
  localparam int unsigned ENT_W      = 8;
  localparam int unsigned EN_BIT     = 7;
  localparam int unsigned CHF_W      = 5;
  localparam int unsigned IDX_W      = 7;
  localparam int unsigned LO_BASE    = 32'h100;
  localparam int unsigned LO_COUNT   = 64;
  localparam int unsigned HI_BASE    = 32'h1100;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } map_sel_t;

  // Address to entry index; status words and gaps give no hit.
  function automatic map_sel_t map_select(input logic [15:0] a, input int unsigned nreq);
    map_sel_t    s;
    int unsigned ai;
    int unsigned k;
    s  = '0;
    ai = 32'(a);
    k  = 0;
    if (a[1:0] == 2'b00) begin
      if (ai >= LO_BASE && ai < LO_BASE + 4 * LO_COUNT) begin
        k     = (ai - LO_BASE) / 4;
        s.hit = (k < nreq);
      end else if (ai >= HI_BASE && ai < HI_BASE + 4 * (nreq - LO_COUNT)) begin
        k     = LO_COUNT + (ai - HI_BASE) / 4;
        s.hit = 1'b1;
      end
    end
    s.idx = k[IDX_W-1:0];
    return s;
  endfunction

  function automatic logic bad_channel(input logic [ENT_W-1:0] v, input int unsigned nch);
    return v[EN_BIT] && (32'(v[CHF_W-1:0]) >= nch);
  endfunction

  function automatic logic [ENT_W-1:0] sanitize(input logic [ENT_W-1:0] v, input int unsigned nch);
    logic [ENT_W-1:0] r;
    r = v;
    if (bad_channel(v, nch)) r[EN_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/rr_map_table.sv
module rr_map_table
  import dma_rr_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [ENT_W-1:0]                  wr_val,
  output logic [NUM_REQ-1:0][ENT_W-1:0]     map_o,
  output logic                              err_o
);
  logic wr_bad;
  assign wr_bad = bad_channel(wr_val, NUM_CH);

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  map_o[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))       map_o[i] <= sanitize(wr_val, NUM_CH);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= wr_en && wr_bad;
  end

  AST_BAD_CH_STORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bad) |=> (err_o && !map_o[$past(wr_idx)][EN_BIT])); // R9
  AST_ERR_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(wr_en)); // R9
endmodule

// File: rtl/rr_route.sv
module rr_route
  import dma_rr_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic [NUM_REQ-1:0]             req,
  input  logic [NUM_REQ-1:0]             ent_en,
  input  logic [NUM_REQ-1:0][CHF_W-1:0]  ent_ch,
  output logic [NUM_CH-1:0]              lvl_next
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      lvl_next[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++)
        lvl_next[c] = lvl_next[c] | (req[r] & ent_en[r] & (ent_ch[r] == CHF_W'(c)));
    end
  end
endmodule

// File: rtl/rr_edge.sv
module rr_edge #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] lvl_next,
  output logic [NUM_CH-1:0] lvl_o,
  output logic [NUM_CH-1:0] ras_o,
  output logic [NUM_CH-1:0] eor_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= '0;
      ras_o <= '0;
      eor_o <= '0;
    end else begin
      lvl_o <= lvl_next;
      ras_o <= lvl_next & ~lvl_o;
      eor_o <= ~lvl_next & lvl_o;
    end
  end

  AST_RISE_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_o & ~lvl_o) == '0); // R7
  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|ras_o) |-> ((ras_o & $past(lvl_o)) == '0)); // R7
  AST_FALL_WITHOUT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_o & lvl_o) == '0); // R8
  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (|eor_o) |-> ((eor_o & ~$past(lvl_o)) == '0)); // R8
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dma_rr_pkg::*;
#(
  parameter int unsigned NUM_REQ = 75,
  parameter int unsigned NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [15:0]        reg_addr,
  input  logic [ENT_W-1:0]   reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  ch_level,
  output logic [NUM_CH-1:0]  ch_ras_pulse,
  output logic [NUM_CH-1:0]  ch_eor_pulse,
  output logic               map_err
);
  map_sel_t                          sel;
  logic [NUM_REQ-1:0][ENT_W-1:0]     map_q;
  logic [NUM_REQ-1:0]                ent_en;
  logic [NUM_REQ-1:0][CHF_W-1:0]     ent_ch;
  logic [NUM_CH-1:0]                 lvl_next;
  logic                              map_wr;

  assign sel    = map_select(reg_addr, NUM_REQ);
  assign map_wr = reg_wr && sel.hit;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_split
    assign ent_en[i] = map_q[i][EN_BIT];
    assign ent_ch[i] = map_q[i][CHF_W-1:0];
  end

  assign reg_rdata = sel.hit ? {{(32-ENT_W){1'b0}}, map_q[sel.idx]} : 32'h0;

  rr_map_table #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(map_wr), .wr_idx(sel.idx),
    .wr_val(reg_wdata), .map_o(map_q), .err_o(map_err)
  );

  rr_route #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
    .req(req_in), .ent_en(ent_en), .ent_ch(ent_ch), .lvl_next(lvl_next)
  );

  rr_edge #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_next(lvl_next),
    .lvl_o(ch_level), .ras_o(ch_ras_pulse), .eor_o(ch_eor_pulse)
  );

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ras_pulse & ch_eor_pulse) == '0); // R7
  AST_STATUS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 16'h00E0 || reg_addr == 16'h00E4 || reg_addr == 16'h00E8) |-> (reg_rdata == 32'h0)); // R4
endmodule

// File: tb/dma_req_router_bench.sv
module dma_req_router_bench;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0;
  logic [15:0]     reg_addr = '0;
  logic [7:0]      reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NREQ-1:0] req_in = '0;
  logic [NCH-1:0]  ch_level, ch_ras_pulse, ch_eor_pulse;
  logic            map_err;
  int              n_run = 0;
  int              n_fail = 0;

  always #2 clk = ~clk;

  dma_req_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u_dma_req_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .ch_level(ch_level), .ch_ras_pulse(ch_ras_pulse), .ch_eor_pulse(ch_eor_pulse),
    .map_err(map_err)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] ent_addr(input int i);
    return (i < 64) ? 16'(32'h100 + 4 * i) : 16'(32'h1100 + 4 * (i - 64));
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 level", 32'(ch_level), 0);
    chk("R1 pulses", 32'(ch_ras_pulse | ch_eor_pulse), 0);
    chk("R1 err", 32'(map_err), 0);
    rd(ent_addr(0), d);  chk("R1 entry0", d, 0);
    rd(ent_addr(74), d); chk("R1 entry74", d, 0);
  endtask

  task automatic t_window_lo;
    logic [31:0] d;
    wr(ent_addr(5), 8'h83);  rd(ent_addr(5), d);  chk("R2 entry5", d, 32'h83);
    wr(ent_addr(63), 8'h41); rd(ent_addr(63), d); chk("R2 entry63", d, 32'h41);
  endtask

  task automatic t_window_hi;
    logic [31:0] d;
    wr(16'h1100, 8'h8A); rd(16'h1100, d); chk("R3 entry64", d, 32'h8A);
    wr(16'h1128, 8'h82); rd(16'h1128, d); chk("R3 entry74", d, 32'h82);
    rd(ent_addr(0), d); chk("R3 no alias entry0", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    for (int k = 0; k < 3; k++) begin
      wr(16'(32'hE0 + 4 * k), 8'hFF);
      rd(16'(32'hE0 + 4 * k), d); chk("R4 status zero", d, 0);
    end
    rd(ent_addr(5), d); chk("R4 entry5 kept", d, 32'h83);
    rd(ent_addr(0), d); chk("R4 entry0 kept", d, 0);
  endtask

  task automatic t_gap;
    logic [31:0] d;
    wr(16'h0200, 8'h85); wr(16'h1000, 8'h85); wr(16'h112C, 8'h85);
    rd(16'h0200, d); chk("R11 gap read", d, 0);
    rd(16'h112C, d); chk("R11 past hi read", d, 0);
    rd(ent_addr(0), d); chk("R11 entry0 kept", d, 0);
    rd(ent_addr(1), d); chk("R11 entry1 kept", d, 0);
  endtask

  task automatic t_route;
    @(negedge clk); req_in[5] = 1'b1;
    step; chk("R5 ch3 level", 32'(ch_level), 32'h8);
          chk("R7 ras ch3", 32'(ch_ras_pulse), 32'h8);
    step; chk("R7 ras one cycle", 32'(ch_ras_pulse), 0);
          chk("R5 level held", 32'(ch_level), 32'h8);
    req_in[5] = 1'b0;
    step; chk("R8 level drop", 32'(ch_level), 0);
          chk("R8 eor ch3", 32'(ch_eor_pulse), 32'h8);
    step; chk("R8 eor one cycle", 32'(ch_eor_pulse), 0);
  endtask

  task automatic t_invalid;
    @(negedge clk); req_in[63] = 1'b1;
    step; chk("R6 no level", 32'(ch_level), 0);
          chk("R6 no pulse", 32'(ch_ras_pulse), 0);
    step; req_in[63] = 1'b0;
    step; chk("R6 no eor", 32'(ch_eor_pulse), 0);
  endtask

  task automatic t_shared;
    wr(16'h1128, 8'h8A);
    @(negedge clk); req_in[64] = 1'b1;
    step; chk("R10 first rise", 32'(ch_ras_pulse), 32'h400);
    req_in[74] = 1'b1;
    step; step; chk("R10 no second ras", 32'(ch_ras_pulse), 0);
    req_in[64] = 1'b0;
    step; chk("R10 level kept", 32'(ch_level), 32'h400);
          chk("R10 no partial eor", 32'(ch_eor_pulse), 0);
    req_in[74] = 1'b0;
    step; chk("R10 final eor", 32'(ch_eor_pulse), 32'h400);
  endtask

  task automatic t_badch;
    logic [31:0] d;
    @(negedge clk); reg_addr = ent_addr(1); reg_wdata = 8'h93; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R9 err raised", 32'(map_err), 1);
    step; chk("R9 err one cycle", 32'(map_err), 0);
    rd(ent_addr(1), d); chk("R9 stored disabled", d, 32'h13);
    req_in[1] = 1'b1;
    step; step; chk("R9 no routing", 32'(ch_level), 0);
    req_in[1] = 1'b0;
    @(negedge clk); reg_addr = ent_addr(2); reg_wdata = 8'h8F; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R9 valid ch no err", 32'(map_err), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step;
    t_reset;
    t_window_lo;
    t_window_hi;
    t_status;
    t_gap;
    t_route;
    t_invalid;
    t_shared;
    t_badch;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule